// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an asynchronous static RAM that has a single shared 8-bit data bus. Each host request is one word, either a read or a write. The block turns that request into the active-low chip-enable, output-enable and write-enable strobes the memory needs. It holds the address steady for the whole access and drives the data pins only while it owns them.

The host side is a valid/ready stream. A request moves on the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle. A host that keeps `req_valid` high while `req_ready` is low is simply held off: nothing is sampled in those cycles and no queue builds up. Read results come back as a one-cycle pulse on `rsp_valid`, and that output has no back-pressure.

The memory's timing limits are given as picosecond parameters. The clock period is a parameter too. Each phase takes the ceiling of its limit divided by the period, and never less than one cycle. At the default 8 ns clock, a read access lasts 2 cycles and a write pulse lasts 2 cycles.

Top module: `sram_seq`

## Requirements
- R1: While reset is held and after it is released, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 from the cycle after acceptance until the access ends. A request presented while `req_ready` is 0 leaves the memory contents unchanged. `req_write` = 1 selects a write.
- R3: A read drives `mem_ce_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1, starting in the cycle after acceptance. These levels last for RD_CYC cycles, where RD_CYC is the largest of ceil(15 ns/T), ceil(9 ns/T) and ceil(15 ns/T) (2 at T = 8 ns). `req_ready` returns to 1 right after.
- R4: Read data is sampled from `mem_dq_i` on the last access cycle. It appears on `rsp_rdata` with `rsp_valid` = 1 for exactly one cycle, which is the cycle in which `req_ready` returns to 1.
- R5: A write drives `mem_ce_n` = 0 and `mem_we_n` = 0 together, with `mem_oe_n` = 1, starting in the cycle after acceptance. These levels last for WR_CYC cycles, the largest of ceil(11 ns/T), ceil(10 ns/T) and ceil(15 ns/T) (2 at T = 8 ns). `mem_dq_o` carries the write data throughout.
- R6: `mem_dq_oe` is 1 for the write-enable cycles plus exactly one hold cycle after `mem_we_n` rises, and at no other time. `mem_oe_n` is never 0 while `mem_dq_oe` is 1.
- R7: After the hold cycle, one idle turnaround cycle follows before `req_ready` returns, so a write keeps `req_ready` low for WR_CYC + 2 cycles.
- R8: `mem_addr` equals the accepted address throughout every strobe and data-drive cycle of the access.
- R9: A word written to an address is returned by any later read of that address, until that address is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | DATA_W | Read result |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data toward the memory pins |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | DATA_W | Data from the memory pins |

## Verification
The hardest case to reach from the ports is a request that arrives while the sequencer is busy, because the host normally waits for `req_ready`. The bench deliberately raises `req_valid` with a conflicting write during every read. It then reads the targeted address later to show the stray request left no trace. Its memory model returns a poison byte until the read enables have been held long enough, so a read phase that is too short shows up as wrong data. The model also flags any cycle where both sides drive the data pins.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_READ  = 3'd1,
    SQ_WRITE = 3'd2,
    SQ_HOLD  = 3'd3,
    SQ_TURN  = 3'd4
  } seq_state_t;

  // cycles needed to cover a limit, never fewer than one
  function automatic int span_cycles(input int limit_ps, input int period_ps);
    int n;
    n = (limit_ps + period_ps - 1) / period_ps;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                remain_q <= '0;
    else if (load)             remain_q <= load_val;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic rd_last,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe
);
  localparam int LONGEST = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

  seq_state_t       state_q, state_nx;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  assign req_ready = (state_q == SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (state_q == SQ_READ) && expired;

  always_comb begin
    state_nx = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      SQ_IDLE: if (req_valid) begin
        load = 1'b1;
        if (req_write) begin
          state_nx = SQ_WRITE;
          load_val = CNT_W'(WR_CYC - 1);
        end else begin
          state_nx = SQ_READ;
          load_val = CNT_W'(RD_CYC - 1);
        end
      end
      SQ_READ:  if (expired) state_nx = SQ_IDLE;
      SQ_WRITE: if (expired) state_nx = SQ_HOLD;
      SQ_HOLD:  state_nx = SQ_TURN;
      SQ_TURN:  state_nx = SQ_IDLE;
      default:  state_nx = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ce_n    <= 1'b1;
      oe_n    <= 1'b1;
      we_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_nx;
      ce_n    <= !((state_nx == SQ_READ) || (state_nx == SQ_WRITE));
      oe_n    <= !(state_nx == SQ_READ);
      we_n    <= !(state_nx == SQ_WRITE);
      dq_oe   <= (state_nx == SQ_WRITE) || (state_nx == SQ_HOLD);
    end
  end

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  // R6
  hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);
  // R5
  we_with_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && dq_oe));
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R7
  turn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (!req_ready && ce_n));
endmodule

// File: rtl/sram_seq_dpath.sv
module sram_seq_dpath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      rsp_valid <= rd_last;
      if (rd_last) rsp_rdata <= mem_dq_i;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !$past(accept)) |=> $stable(mem_addr));
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 8000,
  parameter int T_ACC_PS  = 15000,
  parameter int T_OEA_PS  = 9000,
  parameter int T_CYC_PS  = 15000,
  parameter int T_WPW_PS  = 11000,
  parameter int T_DSU_PS  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC = max3(span_cycles(T_ACC_PS, CLK_PS),
                               span_cycles(T_OEA_PS, CLK_PS),
                               span_cycles(T_CYC_PS, CLK_PS));
  localparam int WR_CYC = max3(span_cycles(T_WPW_PS, CLK_PS),
                               span_cycles(T_DSU_PS, CLK_PS),
                               span_cycles(T_CYC_PS, CLK_PS));

  logic accept, rd_last;

  sram_seq_ctrl #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .rd_last(rd_last),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(mem_dq_oe)
  );

  sram_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rd_last(rd_last),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: tb/sram_seq_test.sv
module sram_seq_test;
  localparam int AW  = 8;
  localparam int DW  = 8;
  localparam int TCK = 8000;
  localparam int RD_EXP = 2;   // ceil(15000/8000)
  localparam int WR_EXP = 2;   // max(ceil(11000/8000), ceil(10000/8000), ceil(15000/8000))
  localparam logic [7:0] POISON = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(TCK)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model
  logic [DW-1:0] ram [256];
  int rd_run = 0;
  wire rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (rd_on && rd_run >= RD_EXP - 1) ? ram[mem_addr] : POISON;
  always @(posedge clk) rd_run <= rd_on ? rd_run + 1 : 0;
  always @(negedge clk) if (!mem_ce_n && !mem_we_n && mem_dq_oe) ram[mem_addr] <= mem_dq_o;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus contention monitor (R6)
  always @(negedge clk) if (rst_n && mem_dq_oe && rd_on)
    chk(0, "R6 contention", 1, 0);

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + 11 + k * 101) ^ (k * 8'h3C));
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int busy, wel, dqc, badaddr, baddata, first_we;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    busy = 0; wel = 0; dqc = 0; badaddr = 0; baddata = 0;
    first_we = mem_we_n;
    while (!req_ready) begin
      busy++;
      if (!mem_we_n) begin
        wel++;
        if (mem_ce_n || !mem_oe_n) baddata++;
      end
      if (mem_dq_oe) begin
        dqc++;
        if (mem_dq_o != d) baddata++;
      end
      if ((!mem_ce_n || mem_dq_oe) && mem_addr != a) badaddr++;
      @(negedge clk);
      if (busy > 50) break;
    end
    chk(first_we == 0, "R5 write starts after accept", first_we, 0);
    chk(wel == WR_EXP, "R5 write pulse cycles", wel, WR_EXP);
    chk(baddata == 0, "R5 write strobes/data", baddata, 0);
    chk(dqc == WR_EXP + 1, "R6 drive cycles", dqc, WR_EXP + 1);
    chk(busy == WR_EXP + 2, "R7 write busy", busy, WR_EXP + 2);
    chk(badaddr == 0, "R8 addr stable write", badaddr, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                         input bit poke, input logic [AW-1:0] pa);
    int busy, oel, badaddr, early;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    if (poke) begin
      req_valid = 1; req_write = 1; req_addr = pa; req_wdata = 8'hFF;
    end else req_valid = 0;
    busy = 0; oel = 0; badaddr = 0; early = 0;
    while (!req_ready) begin
      busy++;
      if (rd_on) oel++;
      if (rsp_valid) early++;
      if (!mem_ce_n && mem_addr != a) badaddr++;
      @(negedge clk);
      if (busy == 1 && poke) begin end
      if (busy > 50) break;
    end
    req_valid = 0;
    chk(oel == RD_EXP, "R3 read enable cycles", oel, RD_EXP);
    chk(busy == RD_EXP, "R3 read busy", busy, RD_EXP);
    chk(early == 0, "R4 no early valid", early, 0);
    chk(rsp_valid == 1, "R4 rsp_valid with ready", rsp_valid, 1);
    chk(rsp_rdata == exp, "R9 read data", rsp_rdata, exp);
    chk(badaddr == 0, "R8 addr stable read", badaddr, 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R4 single cycle", rsp_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !rsp_valid, "R1 drive/valid in reset", {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(req_ready && !mem_dq_oe, "R1 ready after reset", {req_ready, mem_dq_oe}, 2);

    // sweep: fill every address
    for (int a = 0; a < 256; a++) do_write(AW'(a), pat(a, 0));
    // read back, each time presenting a stray write while busy (R2)
    for (int a = 0; a < 256; a++) do_read(AW'(a), pat(a, 0), 1'b1, AW'((a + 1) % 256));
    // stray writes must have left the array untouched (R2)
    for (int a = 0; a < 256; a += 17) do_read(AW'(a), pat(a, 0), 1'b0, '0);
    // back-to-back write then read of the same address, new pattern (R7, R9)
    for (int a = 0; a < 256; a += 3) begin
      do_write(AW'(a), pat(a, 1));
      do_read(AW'(a), pat(a, 1), 1'b0, '0);
    end
    // read then write, then check neighbours untouched (R9)
    for (int a = 1; a < 255; a += 29) begin
      do_read(AW'(a - 1), (((a - 1) % 3) == 0) ? pat(a - 1, 1) : pat(a - 1, 0), 1'b0, '0);
      do_write(AW'(a), 8'(a ^ 8'h96));
      do_read(AW'(a), 8'(a ^ 8'h96), 1'b0, '0);
      do_read(AW'(a + 1), (((a + 1) % 3) == 0) ? pat(a + 1, 1) : pat(a + 1, 0), 1'b0, '0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule